// File: doc/BRIEF.md
# Boot Configuration Load Sequencer

This block sits on the host side of an audio signal processor. After the block's reset is released it brings the processor from reset to a running state without help from software. It first counts out the processor's post-reset settling time. It then writes a clock-enable word, stops the processor core, and streams configuration words from a local image memory into up to four target regions. It finishes by writing the core-run word. All writes go out over a plain address/data bus with a valid/ready handshake. The serial transport that carries that bus to the chip lies outside this block.

A small descriptor table sets the bulk load. It holds one base address and one word count for each of four regions, visited in a fixed order: coefficient RAM, instruction RAM, routing-mode registers, then control registers. Each region has a legal address window. A region with a zero count is skipped. A region whose range would leave its window is also skipped, so a bad descriptor can never spill into a neighbouring region. The image memory holds the words of the loaded regions back to back, starting at image address 0. It is read with one cycle of latency, as a block RAM would be.

Top module: `boot_load_sequencer`

## Requirements
- R1: While reset is high and after it falls, `busy` is 1, `done` is 0 and `wr_valid` is 0. No write is offered until at least INIT_CYCLES clock cycles after reset is released.
- R2: The first write goes to CLK_EN_ADDR (default 0xE000) with data CLK_EN_VAL. The second write goes to CORE_ADDR (default 0xE100) with data 0, which clears the run bit. No region write comes before these two.
- R3: Regions are loaded in index order 0 to 3. Region i writes its count words to consecutive addresses base, base+1, and so on. The data are image words taken in ascending image address order, starting at address 0 after reset and continuing across regions. An image word appears on `img_data` one cycle after its address is on `img_addr`.
- R4: A region whose count is 0 produces no write and consumes no image word.
- R5: Each region has a window: index 0 is 0x0000–0x0FFF, index 1 is 0x2000–0x2FFF, index 2 is 0xE080–0xE09B, index 3 is 0xE221–0xE24C. A region with base below its window's low end, or with base+count−1 above its high end, is skipped as in R4.
- R6: Once offered, a write keeps `wr_valid`, `wr_addr` and `wr_data` unchanged until a cycle in which `wr_ready` is 1. A write is accepted in that cycle.
- R7: The last write goes to CORE_ADDR with data RUN_VAL (default 1, bit 0 being the run bit). It is offered only after every region write has been accepted.
- R8: `done` is 1 for exactly one cycle, the cycle after the run write is accepted. In that same cycle `busy` falls and stays 0. No further write is offered until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_base | input | 4×ADDR_W | Base address per region, index 0 in the low slice |
| desc_count | input | 4×CNT_W | Word count per region, 0 skips the region |
| img_addr | output | IMG_AW | Image memory read address |
| img_data | input | DATA_W | Image word, one cycle after its address |
| wr_valid | output | 1 | Write offered |
| wr_ready | input | 1 | Write accepted when high with wr_valid |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| busy | output | 1 | High from reset until the run write is accepted |
| done | output | 1 | One-cycle pulse after the run write is accepted |

## Verification
A wrong region index or a wrong image pointer shows up at the very next accepted write: its address leaves the expected window, or its data no longer matches the image word the bench predicts. A miscounted remaining length shows up when the region boundary is reached, because the write stream gains or loses an entry before the run write. A handshake slip appears within one stalled cycle as a changed address or data while valid is held. A wrong done state appears in the cycle after the run write is accepted.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  localparam int ADDR_W = 16;
  localparam int NREG   = 4;

  // region windows, index 0 in the low slice; order is the load order
  localparam logic [NREG-1:0][ADDR_W-1:0] WIN_LO =
    {16'hE221, 16'hE080, 16'h2000, 16'h0000};
  localparam logic [NREG-1:0][ADDR_W-1:0] WIN_HI =
    {16'hE24C, 16'hE09B, 16'h2FFF, 16'h0FFF};

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_CLKEN,
    ST_HALT,
    ST_SEL,
    ST_CAP,
    ST_WR,
    ST_RUN,
    ST_IDLE
  } seq_state_t;

endpackage

// File: rtl/boot_init_timer.sv
module boot_init_timer #(
  parameter int INIT_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic expired
);
  localparam int CW = $clog2(INIT_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (cnt == CW'(INIT_CYCLES - 1)) expired <= 1'b1;
      else                             cnt     <= cnt + 1'b1;
    end
  end

  // R1
  tmr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    expired |=> expired);

endmodule

// File: rtl/boot_desc_check.sv
module boot_desc_check
  import boot_seq_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic [NREG-1:0][ADDR_W-1:0] desc_base,
  input  logic [NREG-1:0][CNT_W-1:0]  desc_count,
  output logic [NREG-1:0]             region_ok
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [ADDR_W+CNT_W:0] last;
    always_comb begin
      last = (ADDR_W+CNT_W+1)'(desc_base[g]) + (ADDR_W+CNT_W+1)'(desc_count[g])
             - (ADDR_W+CNT_W+1)'(1);
      region_ok[g] = (desc_count[g] != '0)
                  && (desc_base[g] >= WIN_LO[g])
                  && (last <= (ADDR_W+CNT_W+1)'(WIN_HI[g]));
    end
  end
endmodule

// File: rtl/boot_load_sequencer.sv
module boot_load_sequencer
  import boot_seq_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          CNT_W       = 13,
  parameter int          IMG_AW      = 12,
  parameter int          INIT_CYCLES = 1_000_000,
  parameter logic [15:0] CLK_EN_ADDR = 16'hE000,
  parameter logic [31:0] CLK_EN_VAL  = 32'h0000_FFFF,
  parameter logic [15:0] CORE_ADDR   = 16'hE100,
  parameter logic [31:0] RUN_VAL     = 32'h0000_0001
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREG-1:0][ADDR_W-1:0] desc_base,
  input  logic [NREG-1:0][CNT_W-1:0]  desc_count,
  output logic [IMG_AW-1:0]           img_addr,
  input  logic [DATA_W-1:0]           img_data,
  output logic                        wr_valid,
  input  logic                        wr_ready,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic [DATA_W-1:0]           wr_data,
  output logic                        busy,
  output logic                        done
);
  localparam int IW = $clog2(NREG + 1);

  seq_state_t        state;
  logic [IW-1:0]     idx;
  logic [ADDR_W-1:0] addr_cur;
  logic [CNT_W-1:0]  remain;
  logic [IMG_AW-1:0] img_ptr;
  logic [NREG-1:0]   region_ok;
  logic              tmr_expired;
  logic              accept;

  boot_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .expired(tmr_expired)
  );

  boot_desc_check #(.CNT_W(CNT_W)) u_desc (
    .desc_base(desc_base), .desc_count(desc_count), .region_ok(region_ok)
  );

  assign accept   = wr_valid && wr_ready;
  assign img_addr = img_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_WAIT;
      idx      <= '0;
      addr_cur <= '0;
      remain   <= '0;
      img_ptr  <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      busy     <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_WAIT: if (tmr_expired) begin
          wr_valid <= 1'b1;
          wr_addr  <= CLK_EN_ADDR;
          wr_data  <= DATA_W'(CLK_EN_VAL);
          state    <= ST_CLKEN;
        end
        ST_CLKEN: if (accept) begin
          wr_addr <= CORE_ADDR;
          wr_data <= '0;
          state   <= ST_HALT;
        end
        ST_HALT: if (accept) begin
          wr_valid <= 1'b0;
          idx      <= '0;
          state    <= ST_SEL;
        end
        ST_SEL: begin
          if (idx == IW'(NREG)) begin
            wr_valid <= 1'b1;
            wr_addr  <= CORE_ADDR;
            wr_data  <= DATA_W'(RUN_VAL);
            state    <= ST_RUN;
          end else if (!region_ok[idx[IW-2:0]]) begin
            idx <= idx + 1'b1;
          end else begin
            addr_cur <= desc_base[idx[IW-2:0]];
            remain   <= desc_count[idx[IW-2:0]];
            state    <= ST_CAP;
          end
        end
        ST_CAP: begin
          wr_valid <= 1'b1;
          wr_addr  <= addr_cur;
          wr_data  <= img_data;
          img_ptr  <= img_ptr + 1'b1;
          state    <= ST_WR;
        end
        ST_WR: if (accept) begin
          wr_valid <= 1'b0;
          addr_cur <= addr_cur + 1'b1;
          remain   <= remain - 1'b1;
          if (remain == CNT_W'(1)) begin
            idx   <= idx + 1'b1;
            state <= ST_SEL;
          end else begin
            state <= ST_CAP;
          end
        end
        ST_RUN: if (accept) begin
          wr_valid <= 1'b0;
          busy     <= 1'b0;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  // R1
  no_early_write_chk: assert property (@(posedge clk) disable iff (rst)
    !tmr_expired |-> !wr_valid);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R5
  in_window_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR) |-> (wr_addr >= WIN_LO[idx[IW-2:0]]) && (wr_addr <= WIN_HI[idx[IW-2:0]]));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !wr_valid);

endmodule

// File: tb/tb_boot_load_sequencer.sv
module tb_boot_load_sequencer;
  localparam int INIT = 50;
  localparam int MAXW = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0][15:0] desc_base;
  logic [3:0][12:0] desc_count;
  logic [11:0] img_addr;
  logic [31:0] img_data;
  logic wr_valid, wr_ready, busy, done;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;

  int checks = 0, fails = 0;
  int rmode = 0, cyc = 0, nrec = 0, ndone = 0, first_cyc = -1;
  logic busy_at_first;
  logic [15:0] rec_addr [MAXW];
  logic [31:0] rec_data [MAXW];
  logic [15:0] exp_addr [MAXW];
  logic [31:0] exp_data [MAXW];
  int nexp;

  always #5 clk = ~clk;

  boot_load_sequencer #(.INIT_CYCLES(INIT)) dut (
    .clk(clk), .rst(rst), .desc_base(desc_base), .desc_count(desc_count),
    .img_addr(img_addr), .img_data(img_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  function automatic logic [31:0] img_word(logic [11:0] a);
    return 32'hA5C3_0F1E ^ ({20'd0, a} * 32'd2654435761);
  endfunction

  always @(posedge clk) img_data <= img_word(img_addr);

  function automatic logic [15:0] wlo(int i);
    case (i) 0: return 16'h0000; 1: return 16'h2000; 2: return 16'hE080; default: return 16'hE221; endcase
  endfunction
  function automatic logic [15:0] whi(int i);
    case (i) 0: return 16'h0FFF; 1: return 16'h2FFF; 2: return 16'hE09B; default: return 16'hE24C; endcase
  endfunction

  // monitor: decide ready, then record what the DUT sees at the next edge
  always @(negedge clk) begin
    if (rst) begin
      wr_ready <= 1'b0;
    end else begin
      logic r;
      cyc++;
      case (rmode)
        0: r = 1'b1;
        1: r = ($urandom % 4) != 0;
        default: r = ($urandom % 8) == 0;
      endcase
      wr_ready = r;
      if (wr_valid && r) begin
        if (first_cyc < 0) begin first_cyc = cyc; busy_at_first = busy; end
        if (nrec < MAXW) begin rec_addr[nrec] = wr_addr; rec_data[nrec] = wr_data; end
        nrec++;
      end
      if (done) ndone++;
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build_expected();
    int p = 0;
    nexp = 0;
    exp_addr[nexp] = 16'hE000; exp_data[nexp] = 32'h0000_FFFF; nexp++;
    exp_addr[nexp] = 16'hE100; exp_data[nexp] = 32'h0;         nexp++;
    for (int i = 0; i < 4; i++) begin
      int b = int'(desc_base[i]);
      int c = int'(desc_count[i]);
      if (c != 0 && b >= int'(wlo(i)) && b + c - 1 <= int'(whi(i))) begin
        for (int k = 0; k < c; k++) begin
          exp_addr[nexp] = 16'(b + k);
          exp_data[nexp] = img_word(12'(p));
          p++; nexp++;
        end
      end
    end
    exp_addr[nexp] = 16'hE100; exp_data[nexp] = 32'h1; nexp++;
  endtask

  task automatic run_case(string name);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wr_valid == 1'b0, {"R1 valid in reset ", name}, 64'(wr_valid), 0);
    chk(busy == 1'b1, {"R1 busy in reset ", name}, 64'(busy), 1);
    chk(done == 1'b0, {"R1 done in reset ", name}, 64'(done), 0);
    build_expected();
    nrec = 0; ndone = 0; first_cyc = -1; cyc = 0;
    rst = 1'b0;
    for (int t = 0; t < 20000 && ndone == 0; t++) @(negedge clk);
    repeat (6) @(negedge clk);
    // R1 wait
    chk(first_cyc >= INIT, {"R1 first write cycle ", name}, 64'(first_cyc), 64'(INIT));
    chk(busy_at_first == 1'b1, {"R1 busy during load ", name}, 64'(busy_at_first), 1);
    // R3 R4 R5 count of writes
    chk(nrec == nexp, {"R3 R4 R5 write count ", name}, 64'(nrec), 64'(nexp));
    for (int k = 0; k < nexp && k < nrec; k++) begin
      string tag = (k < 2) ? "R2 " : (k == nexp - 1) ? "R7 " : "R3 R6 ";
      chk(rec_addr[k] == exp_addr[k] && rec_data[k] == exp_data[k],
          {tag, name, " write"}, {rec_addr[k], 16'h0, rec_data[k]},
          {exp_addr[k], 16'h0, exp_data[k]});
    end
    // R8
    chk(ndone == 1, {"R8 done pulses ", name}, 64'(ndone), 1);
    chk(busy == 1'b0, {"R8 busy after done ", name}, 64'(busy), 0);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    wr_ready = 1'b0;
    // directed: all valid, upper boundaries hit exactly
    rmode = 0;
    desc_base  = {16'hE24C, 16'hE080, 16'h2FFC, 16'h0000};
    desc_count = {13'd1, 13'd28, 13'd4, 13'd5};
    run_case("full");
    // R4 zero counts skipped
    rmode = 1;
    desc_base  = {16'hE230, 16'hE085, 16'h2000, 16'h0100};
    desc_count = {13'd0, 13'd3, 13'd0, 13'd7};
    run_case("zero");
    // R5 out-of-window descriptors skipped
    rmode = 2;
    desc_base  = {16'hE220, 16'hE09B, 16'h1FFF, 16'h0FFE};
    desc_count = {13'd2, 13'd1, 13'd2, 13'd3};
    run_case("window");
    // R4 R7 nothing to load
    rmode = 1;
    desc_count = '0;
    run_case("empty");
    // random descriptors and ready patterns
    for (int n = 0; n < 6; n++) begin
      rmode = n % 3;
      for (int i = 0; i < 4; i++) begin
        int span = int'(whi(i)) - int'(wlo(i)) + 1;
        desc_count[i] = 13'($urandom % 20);
        if ($urandom % 4 == 0) desc_base[i] = 16'($urandom);
        else desc_base[i] = 16'(int'(wlo(i)) + int'($urandom % span));
      end
      run_case("random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule